// File: doc/BRIEF.md
# DRAM Clock-Rate Change Sequencer

This block sits on the controller side of a DRAM interface. Its job is to move the memory clock to a new rate without breaking the device's timing rules. A one-cycle request starts a fixed walk through these steps:

- switch on-die termination off;
- drop the clock enable so the device enters precharge power-down;
- hold the old clock for a guard interval;
- flip the clock-select line toward the clock generator;
- wait for the generator to report a stable clock;
- hold the new clock for a second guard interval;
- raise the clock enable;
- issue only NOPs for the exit interval;
- write the mode register with DLL reset;
- wait out the DLL lock time.

A one-cycle done pulse marks the first slot in which normal commands may be issued again.

Every interval is a cycle count taken from configuration inputs. The block copies these counts when it accepts the request, so the caller may change the configuration inputs at any later time. While a sequence is running, the block asks for the data pins to be held in high impedance and ignores any further request.

Top module: `freq_change_seq`

## Requirements
- R1: After reset and whenever idle, `cke_o`=1, `odt_o`=1, `cmd_o`=NOP (2'b00), `busy_o`=0, `done_o`=0 and `dq_hiz_o`=0. `clk_sel_o` resets to 0.
- R2: An accepted request first drives `odt_o` low for W(odtoff) cycles while `cke_o` stays high. `cke_o` falls only after that.
- R3: `cke_o` stays low for W(cksre) cycles with `clk_sel_o` unchanged. `clk_sel_o` then inverts once, on the edge that starts the switch phase.
- R4: The switch phase keeps `cke_o` low until the first clock edge at which `clk_stable_i` is sampled high. If `clk_stable_i` is already high, the phase lasts one cycle.
- R5: After the switch phase, `cke_o` stays low for W(cksrx) more cycles and then rises.
- R6: After `cke_o` rises, `cmd_o` is NOP for W(xp) cycles, then MRS with DLL reset (2'b01) for exactly one cycle. `cmd_o` is never MRS while `cke_o` is low.
- R7: After the MRS cycle come W(dllk) NOP cycles. Then `done_o` is high for exactly one cycle, and on the next cycle the block is idle with `odt_o` high again.
- R8: A request that arrives while `busy_o` is high is ignored. The counts are captured when a request is accepted, so later changes on the configuration inputs do not alter the running sequence.
- R9: `busy_o` and `dq_hiz_o` are high from the first cycle after acceptance through the done cycle. `odt_o` is low whenever `cke_o` is low.
- R10: A count of 0 acts as 1, so W(n) = max(n,1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start request, sampled only when idle |
| cfg_odtoff_i | input | CW | Termination-off wait in cycles |
| cfg_cksre_i | input | CW | Old-clock hold after CKE falls |
| cfg_cksrx_i | input | CW | New-clock hold before CKE rises |
| cfg_xp_i | input | CW | NOP cycles after CKE rises |
| cfg_dllk_i | input | CW | DLL lock cycles after the MRS |
| clk_stable_i | input | 1 | Generator reports the new clock stable |
| cke_o | output | 1 | Clock enable to the DRAM |
| cmd_o | output | 2 | Command: 00 NOP, 01 MRS with DLL reset |
| odt_o | output | 1 | On-die termination control |
| dq_hiz_o | output | 1 | Request to tri-state data and mask pins |
| clk_sel_o | output | 1 | Clock-rate select toward the generator |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when normal commands may resume |

## Verification
The bench builds the whole expected per-cycle trace for each sequence and compares it against the outputs cycle by cycle. It covers all-zero counts, all-one counts and mixed larger counts, so an off-by-one in any wait, or a zero count that wraps into a huge wait, moves every later cycle and shows up at once.

The clock-stable input is raised at different delays after the select flips. A design that ignores that input, or that starts the new-clock hold too early, would raise CKE too soon.

A second request with different counts is sent mid-sequence. A design that re-arms itself or recaptures the counts would stretch or restart the trace.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ODTOFF,
    ST_SRE,
    ST_SWITCH,
    ST_SRX,
    ST_XP,
    ST_MRS,
    ST_DLLK,
    ST_DONE
  } fcs_state_t;

  localparam logic [1:0] CMD_NOP = 2'b00;
  localparam logic [1:0] CMD_MRS = 2'b01;

  localparam int unsigned NCFG = 5;
  localparam int unsigned IDX_ODTOFF = 0;
  localparam int unsigned IDX_CKSRE  = 1;
  localparam int unsigned IDX_CKSRX  = 2;
  localparam int unsigned IDX_XP     = 3;
  localparam int unsigned IDX_DLLK   = 4;

  // Reload value for a wait of max(n,1) cycles on a count-down-to-zero timer.
  function automatic int unsigned load_of(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/fcs_cfg_hold.sv
module fcs_cfg_hold #(
  parameter int unsigned CW   = 16,
  parameter int unsigned NCFG = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      capture,
  input  logic [NCFG-1:0][CW-1:0]   cfg_i,
  output logic [NCFG-1:0][CW-1:0]   cfg_q
);

  for (genvar g = 0; g < NCFG; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q[g] <= '0;
      else if (capture) cfg_q[g] <= cfg_i[g];
    end
  end

endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/freq_change_seq.sv
module freq_change_seq
  import fcs_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [CW-1:0] cfg_odtoff_i,
  input  logic [CW-1:0] cfg_cksre_i,
  input  logic [CW-1:0] cfg_cksrx_i,
  input  logic [CW-1:0] cfg_xp_i,
  input  logic [CW-1:0] cfg_dllk_i,
  input  logic          clk_stable_i,
  output logic          cke_o,
  output logic [1:0]    cmd_o,
  output logic          odt_o,
  output logic          dq_hiz_o,
  output logic          clk_sel_o,
  output logic          busy_o,
  output logic          done_o
);

  fcs_state_t state_q, state_d;

  logic [NCFG-1:0][CW-1:0] cfg_in, cfg_q;
  logic                    accept;
  logic                    tmr_load;
  logic [CW-1:0]           tmr_val;
  logic                    wait_done;
  logic                    sel_flip;
  logic                    sel_q;

  assign cfg_in[IDX_ODTOFF] = cfg_odtoff_i;
  assign cfg_in[IDX_CKSRE]  = cfg_cksre_i;
  assign cfg_in[IDX_CKSRX]  = cfg_cksrx_i;
  assign cfg_in[IDX_XP]     = cfg_xp_i;
  assign cfg_in[IDX_DLLK]   = cfg_dllk_i;

  assign accept = (state_q == ST_IDLE) && req_i;

  fcs_cfg_hold #(.CW(CW), .NCFG(NCFG)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .cfg_i   (cfg_in),
    .cfg_q   (cfg_q)
  );

  fcs_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (wait_done)
  );

  function automatic logic [CW-1:0] ld(input logic [CW-1:0] n);
    return CW'(load_of(32'(n)));
  endfunction

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sel_flip = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d  = ST_ODTOFF;
        tmr_load = 1'b1;
        tmr_val  = ld(cfg_odtoff_i);
      end
      ST_ODTOFF: if (wait_done) begin
        state_d  = ST_SRE;
        tmr_load = 1'b1;
        tmr_val  = ld(cfg_q[IDX_CKSRE]);
      end
      ST_SRE: if (wait_done) begin
        state_d  = ST_SWITCH;
        sel_flip = 1'b1;
      end
      ST_SWITCH: if (clk_stable_i) begin
        state_d  = ST_SRX;
        tmr_load = 1'b1;
        tmr_val  = ld(cfg_q[IDX_CKSRX]);
      end
      ST_SRX: if (wait_done) begin
        state_d  = ST_XP;
        tmr_load = 1'b1;
        tmr_val  = ld(cfg_q[IDX_XP]);
      end
      ST_XP: if (wait_done) state_d = ST_MRS;
      ST_MRS: begin
        state_d  = ST_DLLK;
        tmr_load = 1'b1;
        tmr_val  = ld(cfg_q[IDX_DLLK]);
      end
      ST_DLLK: if (wait_done) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (sel_flip) sel_q <= ~sel_q;
    end
  end

  assign cke_o     = !(state_q == ST_SRE || state_q == ST_SWITCH || state_q == ST_SRX);
  assign cmd_o     = (state_q == ST_MRS) ? CMD_MRS : CMD_NOP;
  assign odt_o     = (state_q == ST_IDLE);
  assign busy_o    = (state_q != ST_IDLE);
  assign dq_hiz_o  = busy_o;
  assign done_o    = (state_q == ST_DONE);
  assign clk_sel_o = sel_q;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       clk_stable_i,
  input logic       cke_o,
  input logic [1:0] cmd_o,
  input logic       odt_o,
  input logic       dq_hiz_o,
  input logic       clk_sel_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       sel_flip,
  input logic       wait_done
);

  // R6: no mode-register write while the device is in power-down
  assert_no_cmd_in_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> cmd_o == 2'b00);

  // R6: the MRS occupies a single slot
  assert_single_mrs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o == 2'b01 |=> cmd_o == 2'b00);

  // R9: termination is off whenever CKE is low
  assert_odt_off_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> !odt_o);

  // R9: data pins tri-stated for the whole sequence
  assert_hiz_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> dq_hiz_o);

  // R7: done is a single-cycle pulse followed by idle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o && odt_o);

  // R3: select changes only out of a flip event taken with CKE low
  assert_sel_flip_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_flip |-> !cke_o && wait_done);

  // R3: select never moves without a flip event
  assert_sel_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_flip |=> $stable(clk_sel_o));

  // R8: a request while busy cannot start anything
  assert_req_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i && !done_o) |=> busy_o);

endmodule

bind freq_change_seq fcs_checker u_fcs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_i        (req_i),
  .clk_stable_i (clk_stable_i),
  .cke_o        (cke_o),
  .cmd_o        (cmd_o),
  .odt_o        (odt_o),
  .dq_hiz_o     (dq_hiz_o),
  .clk_sel_o    (clk_sel_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .sel_flip     (sel_flip),
  .wait_done    (wait_done)
);

// File: tb/freq_change_seq_bench.sv
module freq_change_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0;
  logic [CW-1:0] cfg_odtoff_i = '0, cfg_cksre_i = '0, cfg_cksrx_i = '0;
  logic [CW-1:0] cfg_xp_i = '0, cfg_dllk_i = '0;
  logic          clk_stable_i = 1'b1;
  logic          cke_o, odt_o, dq_hiz_o, clk_sel_o, busy_o, done_o;
  logic [1:0]    cmd_o;

  freq_change_seq #(.CW(CW)) u_freq_change_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } item_t;

  item_t q[$];
  int    vectors = 0;
  int    fails = 0;
  logic  exp_sel = 1'b0;
  bit    finished = 1'b0;

  // vector layout: {cke, odt, cmd[1:0], sel, busy, done, hiz}
  function automatic logic [7:0] vec(logic cke, logic odt, logic [1:0] cmd,
                                     logic sel, logic busy, logic done);
    return {cke, odt, cmd, sel, busy, done, busy};
  endfunction

  function automatic int w(int n);
    return (n < 1) ? 1 : n;   // R10
  endfunction

  function automatic logic [7:0] actual();
    return {cke_o, odt_o, cmd_o, clk_sel_o, busy_o, done_o, dq_hiz_o};
  endfunction

  task automatic push(int n, logic [7:0] v, string tag);
    for (int i = 0; i < n; i++) q.push_back('{v, tag});
  endtask

  task automatic check_now(logic [7:0] exp, string tag);
    vectors++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, actual(), exp);
    end
  endtask

  // monitor: compare one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check_now(it.v, it.tag);
    end
  end

  task automatic run_seq(int odtoff, int sre, int srx, int xp, int dllk,
                         int dly, bit poke);
    logic s0, s1;
    s0 = exp_sel;
    s1 = ~exp_sel;
    @(negedge clk);
    req_i        = 1'b1;
    clk_stable_i = 1'b0;
    cfg_odtoff_i = CW'(odtoff);
    cfg_cksre_i  = CW'(sre);
    cfg_cksrx_i  = CW'(srx);
    cfg_xp_i     = CW'(xp);
    cfg_dllk_i   = CW'(dllk);
    @(posedge clk);
    push(w(odtoff), vec(1, 0, 2'b00, s0, 1, 0), "R2 odt-off wait");
    push(w(sre),    vec(0, 0, 2'b00, s0, 1, 0), "R3 old-clock hold");
    push(dly + 1,   vec(0, 0, 2'b00, s1, 1, 0), "R4 switch wait");
    push(w(srx),    vec(0, 0, 2'b00, s1, 1, 0), "R5 new-clock hold");
    push(w(xp),     vec(1, 0, 2'b00, s1, 1, 0), "R6 exit NOPs");
    push(1,         vec(1, 0, 2'b01, s1, 1, 0), "R6 MRS slot");
    push(w(dllk),   vec(1, 0, 2'b00, s1, 1, 0), "R7 DLL lock NOPs");
    push(1,         vec(1, 0, 2'b00, s1, 1, 1), "R7 done pulse");
    push(1,         vec(1, 1, 2'b00, s1, 0, 0), "R7 back to idle");
    exp_sel = s1;
    @(negedge clk);
    req_i = 1'b0;
    while (clk_sel_o === s0 && q.size() > 0) @(negedge clk);
    for (int i = 0; i < dly; i++) @(negedge clk);
    clk_stable_i = 1'b1;
    if (poke) begin
      @(negedge clk);
      req_i        = 1'b1;   // R8: busy, must be ignored
      cfg_cksrx_i  = 16'd40;
      cfg_xp_i     = 16'd40;
      cfg_dllk_i   = 16'd40;
      @(negedge clk);
      req_i = 1'b0;
    end
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(vec(1, 1, 2'b00, 0, 0, 0), "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_now(vec(1, 1, 2'b00, 0, 0, 0), "R1 idle after reset");
    run_seq(1, 1, 1, 1, 1, 0, 0);
    run_seq(0, 0, 0, 0, 0, 2, 0);   // R10 zero counts
    run_seq(3, 5, 4, 6, 10, 3, 1);  // R8 request while busy
    run_seq(2, 0, 7, 3, 8, 1, 1);
    repeat (3) @(negedge clk);
    check_now(vec(1, 1, 2'b00, exp_sel, 0, 0), "R1 stays idle");
    finish_run();
  end

endmodule